// File: doc/BRIEF.md
# USB Host Pipe Status Tracker

This block holds the status of a single pipe in a USB host controller that stores packets in one or two banks. Transaction-level strobes come in from the serial engine and from software. These strobes report a received packet with its length and data toggle, a STALL, a NAK, a CRC error, a bank loaded by software, and a bank finished. From them the block keeps a busy-bank count, the index of the current bank, the data toggle, and five sticky event flags. Software clears each flag by writing a one to its clear bit.

Each flag has its own enable, and so does the busy-bank condition. The enabled sources are combined into one pipe interrupt. A STALL on a pipe that is not isochronous also freezes the pipe. The freeze holds until software pulses the freeze-clear input. All events are single-cycle pulses. All state is registered, so every event shows at the outputs in the cycle after the clock edge that samples it.

Top module: `usb_pipe_status`

## Requirements
- R1: After a synchronous active-low reset, the block shows the following: busy count 0, current bank 0, data toggle 0, all flags 0, pipe not frozen, and no interrupt.
- R2: Bank capacity is 2 when `cfg_dual_bank` is 1 and 1 otherwise. A fill comes from `sw_fill` on an OUT pipe and from `rx_valid` on an IN pipe. A `bank_done` is accepted only when the count is above 0. A fill is accepted when the count is below capacity or when a `bank_done` is accepted in the same cycle. The count rises by 1 for each accepted fill and falls by 1 for each accepted `bank_done`. Code 3 never appears.
- R3: `busy_event` is high on an OUT pipe while the count equals capacity. It is high on an IN pipe while the count is 0.
- R4: With two banks, `curr_bank` inverts on each accepted `bank_done`. With one bank it reads 0. Code 0 is the first bank and code 1 is the second.
- R5: On an OUT pipe, `data_toggle` (0 = DATA0, 1 = DATA1) starts at 0 and inverts on each accepted `bank_done`. On an IN pipe it shows the `rx_toggle` stored with the packet in the current bank. Each accepted fill writes into slot (current bank + count) mod 2, or into slot 0 with one bank.
- R6: On an IN pipe, a received packet sets flag bit 0 (short) when `rx_len` < `cfg_max_len`, and sets flag bit 3 (overflow) when `rx_len` > `cfg_max_len`. A packet of exactly the maximum length sets neither. On an OUT pipe, `rx_valid` has no effect.
- R7: On a pipe that is not isochronous, `hs_stall` sets flag bit 1 and freezes the pipe. On an isochronous pipe, `hs_stall` has no effect.
- R8: `crc_err` sets flag bit 2 only on an isochronous pipe.
- R9: `hs_nak` sets flag bit 4.
- R10: A flag stays set until a one is written to the matching `flag_clr` bit. If a set and a clear reach the same flag in the same cycle, the set wins.
- R11: `pipe_irq` is the OR of all flags ANDed with `flag_en`, together with `busy_event` ANDed with `busy_en`.
- R12: `pipe_frozen` stays high until `freeze_clr` pulses. If a new STALL arrives in the same cycle as `freeze_clr`, the pipe stays frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dual_bank | input | 1 | 1 = two banks configured |
| cfg_dir_in | input | 1 | 1 = IN pipe, 0 = OUT pipe |
| cfg_iso | input | 1 | 1 = isochronous pipe |
| cfg_max_len | input | LEN_W | Programmed maximum packet size |
| rx_valid | input | 1 | Packet received strobe |
| rx_len | input | LEN_W | Length of the received packet |
| rx_toggle | input | 1 | Data toggle of the received packet |
| hs_stall | input | 1 | STALL handshake received |
| hs_nak | input | 1 | NAK handshake received |
| crc_err | input | 1 | CRC error on the current bank |
| sw_fill | input | 1 | Software loaded a bank (OUT) |
| bank_done | input | 1 | Current bank consumed or sent |
| flag_clr | input | 5 | Write-one-to-clear strobes per flag |
| flag_en | input | 5 | Interrupt enables per flag |
| busy_en | input | 1 | Interrupt enable for the busy-bank condition |
| freeze_clr | input | 1 | Release the freeze |
| busy_cnt | output | 2 | Number of busy banks |
| curr_bank | output | 1 | Current bank index |
| data_toggle | output | 1 | Data toggle for the pipe |
| flags | output | 5 | Sticky flags: 0 short, 1 stall, 2 CRC, 3 overflow, 4 NAK |
| busy_event | output | 1 | Busy-bank condition reached |
| pipe_irq | output | 1 | Masked pipe interrupt |
| pipe_frozen | output | 1 | Pipe frozen |

## Verification
A bank fill and a bank release can arrive in the same cycle. The result depends on the count at that moment. From empty, only the fill counts. From full, both count, so a bank is swapped without the count moving. With one bank busy in a pair, the count stays put and the current bank and the toggle still advance. Random stimulus raises both strobes often, in every configuration. Each cycle, a bench model built from the acceptance rules in R2 judges the count, bank index, toggle and busy event. Directed steps add a flag that is set and cleared in the same cycle, and a STALL that arrives together with the freeze release.

// File: rtl/usb_pipe_stat_pkg.sv
// Shared constants for the pipe status block: flag count and bit positions.
package usb_pipe_stat_pkg;
    localparam int NUM_FLAGS = 5;
    localparam int FLG_SHORT = 0;
    localparam int FLG_STALL = 1;
    localparam int FLG_CRC   = 2;
    localparam int FLG_OVF   = 3;
    localparam int FLG_NAK   = 4;
endpackage

// File: rtl/pipe_bank_track.sv
// Tracks busy banks, the current bank and the data toggle for one pipe.
// Assumes fill and release strobes are single-cycle pulses. Capacity is
// taken from cfg_dual (1 or 2 banks). The configuration is held steady
// while traffic runs.
module pipe_bank_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_dual,
    input  logic       cfg_dir_in,
    input  logic       fill_req,
    input  logic       free_req,
    input  logic       rx_toggle,
    output logic [1:0] busy_cnt,
    output logic       curr_bank,
    output logic       data_tog,
    output logic       busy_evt
);
    logic [1:0] cap;
    logic       free_ok;
    logic       fill_ok;
    logic       wr_idx;
    logic       tx_tog;
    logic [1:0] slot_tog;

    // Decide which strobes are accepted this cycle
    always_comb begin
        cap     = cfg_dual ? 2'd2 : 2'd1;
        free_ok = free_req && (busy_cnt != 2'd0);
        fill_ok = fill_req && ((busy_cnt < cap) || free_ok);
        wr_idx  = cfg_dual ? (curr_bank ^ busy_cnt[0]) : 1'b0;
    end

    // Busy-bank counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt <= 2'd0;
        else
            busy_cnt <= busy_cnt + {1'b0, fill_ok} - {1'b0, free_ok};
    end

    // Current bank pointer: alternates only in dual-bank mode
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_dual)
            curr_bank <= 1'b0;
        else if (free_ok)
            curr_bank <= ~curr_bank;
    end

    // OUT toggle: flips after each bank that has been sent
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_tog <= 1'b0;
        else if (!cfg_dir_in && free_ok)
            tx_tog <= ~tx_tog;
    end

    // IN toggles: one stored per bank slot
    for (genvar s = 0; s < 2; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_tog[s] <= 1'b0;
            else if (cfg_dir_in && fill_ok && (wr_idx == s[0]))
                slot_tog[s] <= rx_toggle;
        end
    end

    // Report toggle and busy-bank condition per direction
    always_comb begin
        data_tog = cfg_dir_in ? slot_tog[curr_bank] : tx_tog;
        busy_evt = cfg_dir_in ? (busy_cnt == 2'd0) : (busy_cnt == cap);
    end

    AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt != 2'd3); // R2
    AST_FILL_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && busy_cnt == 2'd0) |=> busy_cnt == 2'd1); // R2
    AST_SINGLE_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dual && $past(!cfg_dual)) |-> !curr_bank); // R4
endmodule

// File: rtl/pipe_event_decode.sv
// Turns transaction strobes into per-flag set pulses and a freeze request.
// Purely combinational. Received-packet checks apply only to IN pipes.
// STALL applies only to pipes that are not isochronous, and CRC errors
// only to isochronous pipes.
module pipe_event_decode
    import usb_pipe_stat_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic                 cfg_dir_in,
    input  logic                 cfg_iso,
    input  logic [LEN_W-1:0]     cfg_max_len,
    input  logic                 rx_valid,
    input  logic [LEN_W-1:0]     rx_len,
    input  logic                 hs_stall,
    input  logic                 hs_nak,
    input  logic                 crc_err,
    output logic [NUM_FLAGS-1:0] set_vec,
    output logic                 freeze_req
);
    logic rx_in;

    // Map each event to its flag bit
    always_comb begin
        rx_in              = rx_valid && cfg_dir_in;
        set_vec            = '0;
        set_vec[FLG_SHORT] = rx_in && (rx_len < cfg_max_len);
        set_vec[FLG_OVF]   = rx_in && (rx_len > cfg_max_len);
        set_vec[FLG_STALL] = hs_stall && !cfg_iso;
        set_vec[FLG_CRC]   = crc_err && cfg_iso;
        set_vec[FLG_NAK]   = hs_nak;
        freeze_req         = hs_stall && !cfg_iso;
    end
endmodule

// File: rtl/pipe_event_flags.sv
// Bank of sticky event flags, one register per flag built by generate.
// Set has priority over a clear that arrives in the same cycle.
module pipe_event_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag: set wins, write-one clears
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (set_vec[i])
                flag_q[i] <= 1'b1;
            else if (clr_vec[i])
                flag_q[i] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_vec[i]) |=> flag_q[i]); // R10
        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]); // R10
    end
endmodule

// File: rtl/usb_pipe_status.sv
// Status and interrupt logic for one USB host pipe with one or two banks.
// Takes transaction-level pulses from the serial engine and from software.
// Produces the bank status, sticky flags, a masked interrupt and a freeze.
// Register decoding and packet storage sit outside this block.
module usb_pipe_status
    import usb_pipe_stat_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_dual_bank,
    input  logic                 cfg_dir_in,
    input  logic                 cfg_iso,
    input  logic [LEN_W-1:0]     cfg_max_len,
    input  logic                 rx_valid,
    input  logic [LEN_W-1:0]     rx_len,
    input  logic                 rx_toggle,
    input  logic                 hs_stall,
    input  logic                 hs_nak,
    input  logic                 crc_err,
    input  logic                 sw_fill,
    input  logic                 bank_done,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic [NUM_FLAGS-1:0] flag_en,
    input  logic                 busy_en,
    input  logic                 freeze_clr,
    output logic [1:0]           busy_cnt,
    output logic                 curr_bank,
    output logic                 data_toggle,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 busy_event,
    output logic                 pipe_irq,
    output logic                 pipe_frozen
);
    logic [NUM_FLAGS-1:0] set_vec;
    logic                 freeze_req;
    logic                 fill_req;

    // Fill source depends on direction: device data on IN, software on OUT
    always_comb fill_req = cfg_dir_in ? rx_valid : sw_fill;

    pipe_bank_track u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_dual   (cfg_dual_bank),
        .cfg_dir_in (cfg_dir_in),
        .fill_req   (fill_req),
        .free_req   (bank_done),
        .rx_toggle  (rx_toggle),
        .busy_cnt   (busy_cnt),
        .curr_bank  (curr_bank),
        .data_tog   (data_toggle),
        .busy_evt   (busy_event)
    );

    pipe_event_decode #(.LEN_W(LEN_W)) u_dec (
        .cfg_dir_in  (cfg_dir_in),
        .cfg_iso     (cfg_iso),
        .cfg_max_len (cfg_max_len),
        .rx_valid    (rx_valid),
        .rx_len      (rx_len),
        .hs_stall    (hs_stall),
        .hs_nak      (hs_nak),
        .crc_err     (crc_err),
        .set_vec     (set_vec),
        .freeze_req  (freeze_req)
    );

    pipe_event_flags #(.N(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (flag_clr),
        .flag_q  (flags)
    );

    // Freeze: set by a STALL on a pipe that is not isochronous, held until released
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe_frozen <= 1'b0;
        else if (freeze_req)
            pipe_frozen <= 1'b1;
        else if (freeze_clr)
            pipe_frozen <= 1'b0;
    end

    // Masked interrupt from flags and busy-bank condition
    always_comb pipe_irq = (|(flags & flag_en)) || (busy_event && busy_en);

    AST_FRZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_frozen && !freeze_clr) |=> pipe_frozen); // R12
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_stall && !cfg_iso) |=> (pipe_frozen && flags[FLG_STALL])); // R7
    AST_CRC_ISO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_CRC]) |-> $past(cfg_iso && crc_err)); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_irq |-> ((|flags) || busy_event)); // R11
endmodule

// File: tb/tb_usb_pipe_status.sv
module tb_usb_pipe_status;
    localparam int LW = 11;
    localparam int NF = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_dual_bank, cfg_dir_in, cfg_iso;
    logic [LW-1:0] cfg_max_len, rx_len;
    logic rx_valid, rx_toggle, hs_stall, hs_nak, crc_err, sw_fill, bank_done;
    logic [NF-1:0] flag_clr, flag_en;
    logic busy_en, freeze_clr;
    logic [1:0] busy_cnt;
    logic curr_bank, data_toggle, busy_event, pipe_irq, pipe_frozen;
    logic [NF-1:0] flags;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int m_cnt, m_curr, m_tx, m_frz;
    int m_slot [2];
    logic [NF-1:0] m_flags;

    always #4 clk = ~clk;

    usb_pipe_status #(.LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_dual_bank(cfg_dual_bank),
        .cfg_dir_in(cfg_dir_in), .cfg_iso(cfg_iso), .cfg_max_len(cfg_max_len),
        .rx_valid(rx_valid), .rx_len(rx_len), .rx_toggle(rx_toggle),
        .hs_stall(hs_stall), .hs_nak(hs_nak), .crc_err(crc_err),
        .sw_fill(sw_fill), .bank_done(bank_done), .flag_clr(flag_clr),
        .flag_en(flag_en), .busy_en(busy_en), .freeze_clr(freeze_clr),
        .busy_cnt(busy_cnt), .curr_bank(curr_bank), .data_toggle(data_toggle),
        .flags(flags), .busy_event(busy_event), .pipe_irq(pipe_irq),
        .pipe_frozen(pipe_frozen)
    );

    function automatic int cap_of(logic dual);
        return dual ? 2 : 1;
    endfunction

    function automatic int exp_busy_evt();
        return cfg_dir_in ? int'(m_cnt == 0) : int'(m_cnt == cap_of(cfg_dual_bank));
    endfunction

    function automatic int exp_toggle();
        return cfg_dir_in ? m_slot[m_curr] : m_tx;
    endfunction

    function automatic int exp_irq();
        return int'((|(m_flags & flag_en)) || (exp_busy_evt() != 0 && busy_en));
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the model by one clock using the inputs currently driven
    task automatic model_step();
        logic fill, free_ok, fill_ok, rxi;
        logic [NF-1:0] setv;
        int wr;
        if (!rst_n) begin
            m_cnt = 0; m_curr = 0; m_tx = 0; m_frz = 0;
            m_slot[0] = 0; m_slot[1] = 0; m_flags = '0;
            return;
        end
        fill    = cfg_dir_in ? rx_valid : sw_fill;
        free_ok = bank_done && (m_cnt > 0);
        fill_ok = fill && ((m_cnt < cap_of(cfg_dual_bank)) || free_ok);
        wr      = cfg_dual_bank ? ((m_curr + m_cnt) % 2) : 0;
        if (cfg_dir_in && fill_ok) m_slot[wr] = int'(rx_toggle);
        if (!cfg_dir_in && free_ok) m_tx = 1 - m_tx;
        if (!cfg_dual_bank) m_curr = 0;
        else if (free_ok) m_curr = 1 - m_curr;
        m_cnt = m_cnt + int'(fill_ok) - int'(free_ok);
        rxi = rx_valid && cfg_dir_in;
        setv = '0;
        setv[0] = rxi && (rx_len < cfg_max_len);
        setv[3] = rxi && (rx_len > cfg_max_len);
        setv[1] = hs_stall && !cfg_iso;
        setv[2] = crc_err && cfg_iso;
        setv[4] = hs_nak;
        m_flags = setv | (m_flags & ~flag_clr);
        if (hs_stall && !cfg_iso) m_frz = 1;
        else if (freeze_clr) m_frz = 0;
    endtask

    task automatic compare_all();
        chk("R2 busy_cnt", int'(busy_cnt), m_cnt);
        chk("R4 curr_bank", int'(curr_bank), m_curr);
        chk("R5 data_toggle", int'(data_toggle), exp_toggle());
        chk("R3 busy_event", int'(busy_event), exp_busy_evt());
        chk("R6 short flag", int'(flags[0]), int'(m_flags[0]));
        chk("R6 overflow flag", int'(flags[3]), int'(m_flags[3]));
        chk("R7 stall flag", int'(flags[1]), int'(m_flags[1]));
        chk("R8 crc flag", int'(flags[2]), int'(m_flags[2]));
        chk("R9 nak flag", int'(flags[4]), int'(m_flags[4]));
        chk("R11 pipe_irq", int'(pipe_irq), exp_irq());
        chk("R12 pipe_frozen", int'(pipe_frozen), m_frz);
    endtask

    task automatic idle_pulses();
        rx_valid = 0; hs_stall = 0; hs_nak = 0; crc_err = 0;
        sw_fill = 0; bank_done = 0; flag_clr = '0; freeze_clr = 0;
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        idle_pulses();
    endtask

    task automatic do_reset(logic dual, logic dir_in, logic iso, int maxl);
        rst_n = 0;
        cfg_dual_bank = dual; cfg_dir_in = dir_in; cfg_iso = iso;
        cfg_max_len = LW'(maxl);
        idle_pulses();
        cyc(); cyc();
        rst_n = 1;
    endtask

    task automatic rand_cycle();
        rx_valid  = ($urandom % 3) == 0;
        rx_len    = LW'(int'(cfg_max_len) - 2 + int'($urandom % 5));
        rx_toggle = $urandom % 2;
        sw_fill   = ($urandom % 3) == 0;
        bank_done = ($urandom % 3) == 0;
        hs_stall  = ($urandom % 16) == 0;
        hs_nak    = ($urandom % 8) == 0;
        crc_err   = ($urandom % 8) == 0;
        flag_clr  = (($urandom % 4) == 0) ? NF'($urandom) : '0;
        freeze_clr = ($urandom % 6) == 0;
        cyc();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        flag_en = '0; busy_en = 0; rx_len = '0; rx_toggle = 0;
        do_reset(1, 1, 0, 16);
        // R1: state right after reset, enables off
        chk("R1 reset busy_cnt", int'(busy_cnt), 0);
        chk("R1 reset curr_bank", int'(curr_bank), 0);
        chk("R1 reset toggle", int'(data_toggle), 0);
        chk("R1 reset flags", int'(flags), 0);
        chk("R1 reset frozen", int'(pipe_frozen), 0);
        chk("R1 reset irq", int'(pipe_irq), 0);

        // directed: dual IN, fill twice, third fill ignored (R2)
        flag_en = '1; busy_en = 1;
        rx_valid = 1; rx_len = 16; rx_toggle = 1; cyc();
        rx_valid = 1; rx_len = 16; rx_toggle = 0; cyc();
        rx_valid = 1; rx_len = 16; rx_toggle = 1; cyc();
        chk("R2 saturate at two", int'(busy_cnt), 2);
        chk("R6 exact length sets no flag", int'(flags), 0);
        // same-cycle fill and release when full (R2, R4)
        rx_valid = 1; rx_len = 16; bank_done = 1; cyc();
        chk("R2 swap keeps count", int'(busy_cnt), 2);
        chk("R4 bank advanced", int'(curr_bank), 1);
        // set and clear of the NAK flag in one cycle: set wins (R10)
        hs_nak = 1; flag_clr = 5'b10000; cyc();
        chk("R10 set beats clear", int'(flags[4]), 1);
        flag_clr = 5'b10000; cyc();
        chk("R10 clear by write one", int'(flags[4]), 0);
        // STALL together with freeze release on non-iso pipe (R12)
        hs_stall = 1; freeze_clr = 1; cyc();
        chk("R12 stall beats release", int'(pipe_frozen), 1);
        freeze_clr = 1; cyc();
        chk("R12 released", int'(pipe_frozen), 0);

        // directed: OUT pipe ignores rx_valid (R6)
        do_reset(0, 0, 1, 8);
        rx_valid = 1; rx_len = 2; cyc();
        chk("R6 rx ignored on OUT", int'(flags) + int'(busy_cnt), 0);
        hs_stall = 1; cyc();
        chk("R7 stall ignored on iso", int'(pipe_frozen) + int'(flags[1]), 0);

        // random phases over every configuration
        for (int p = 0; p < 16; p++) begin
            do_reset(p[0], p[1], p[2], 6 + int'($urandom % 60));
            flag_en = NF'($urandom);
            busy_en = p[3];
            for (int k = 0; k < 500; k++) rand_cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule